// File: doc/BRIEF.md
# HD Line CRC Dual Checker

This block checks the per-line error-detection codes on a high-definition parallel video stream. The stream has two 10-bit channels, luminance and chrominance, which move together one word per clock under a shared valid strobe. A separate decoder in front of the block reports the timing reference codes. It marks the word that closes a start-of-active-video code and the word that closes an end-of-active-video code.

Each channel has its own 18-bit CRC register. The register restarts after every start code and runs through the active words, the end code and the two line-number words. The two words that follow carry the CRC that the transmitter computed. The block rebuilds that 18-bit value from the two words and compares it with its own result. On a mismatch it gives a one-clock error pulse for that channel. It also sets a sticky bit for the host register block, which stays set until the host clears it.

Top module: `hdcrc_line_checker`

## Requirements
- R1: Each channel uses an 18-bit CRC with generator x^18+x^5+x^4+1. The CRC takes the 10 bits of a word least-significant bit first. For each bit b: fb = crc[0] ^ b, then crc = crc >> 1, then if fb is 1, crc ^= 18'h23000.
- R2: The luma and chroma CRCs are independent. A bad check value on one channel flags only that channel.
- R3: The CRC register is zero after reset. It is cleared on the valid word marked with `sav_mark`. Accumulation begins with the next valid word, so words on or before the start marker do not count.
- R4: Accumulation runs through the valid word marked with `eav_mark` and then through the next two valid words, which are the line-number words.
- R5: The first valid word after the line-number words carries received CRC bits 8:0 in its bits 8:0. The second carries bits 17:9 in its bits 8:0. Bit 9 of both words plays no part in the check.
- R6: One clock after the second check word is taken, the error pulse of a channel is high for exactly one cycle, and only if the received value differs from the computed one.
- R7: A channel's sticky bit is set by its error pulse. It holds until `err_clr` is high on a clock edge. If an error and a clear occur on the same edge, the bit ends up set.
- R8: A word with `word_vld` low changes neither the CRCs nor the line position.
- R9: An end marker that arrives when no line has started since the last check, or since reset, starts no check and produces no pulse.
- R10: A start marker that arrives inside a line abandons that line and restarts accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_vld | input | 1 | Both channel inputs carry a word this cycle |
| sav_mark | input | 1 | This word ends a start-of-active-video code |
| eav_mark | input | 1 | This word ends an end-of-active-video code |
| luma_in | input | 10 | Luminance channel word |
| chroma_in | input | 10 | Chrominance channel word |
| err_clr | input | 1 | Host clear for both sticky bits |
| luma_err_pulse | output | 1 | One-cycle luma CRC mismatch |
| chroma_err_pulse | output | 1 | One-cycle chroma CRC mismatch |
| luma_err_sticky | output | 1 | Luma mismatch seen since last clear |
| chroma_err_sticky | output | 1 | Chroma mismatch seen since last clear |

## Verification
The assertions assume that a timing marker only comes with a valid word and that the start and end markers never come together. The stimulus builds every line from a full timing code whose last word carries the single marker, and it drives both markers low on every gap cycle. The pulse and sticky properties also rely on the framing: the two check words always arrive in order, because the bench sends each line as start code, body, end code, line-number words and check words. Inside this framing, the bench sweeps line length, gap pattern, the corrupted bit on each channel and the polarity of bit 9.

// File: rtl/hdcrc_pkg.sv
package hdcrc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BODY,
    PH_LNUM,
    PH_CRLO,
    PH_CRHI
  } phase_e;

  typedef struct packed {
    logic restart;
    logic advance;
    logic cap_lo;
    logic cap_hi;
  } step_t;

endpackage

// File: rtl/hdcrc_lfsr.sv
module hdcrc_lfsr #(
  parameter int DATA_W = 10,
  parameter int CRC_W  = 18,
  parameter logic [CRC_W-1:0] POLY = 18'h00031
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);

  logic [CRC_W-1:0] poly_ref;
  logic [CRC_W-1:0] stage [0:DATA_W];
  logic [CRC_W-1:0] crc_d;

  for (genvar k = 0; k < CRC_W; k++) begin : g_reflect
    assign poly_ref[CRC_W-1-k] = POLY[k];
  end

  assign stage[0] = crc_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][0] ^ din[i];
    assign stage[i+1] = (stage[i] >> 1) ^ ({CRC_W{fb}} & poly_ref);
  end

  always_comb begin
    crc_d = crc_q;
    if (restart) begin
      crc_d = '0;
    end else if (advance) begin
      crc_d = stage[DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (restart || advance) begin
      crc_q <= crc_d;
    end
  end

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (crc_q == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !advance) |=> $stable(crc_q));

endmodule

// File: rtl/hdcrc_seq.sv
module hdcrc_seq #(
  parameter int LN_WORDS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_vld,
  input  logic             sav_mark,
  input  logic             eav_mark,
  output hdcrc_pkg::step_t ctl
);
  import hdcrc_pkg::*;

  localparam int CNT_W = (LN_WORDS > 1) ? $clog2(LN_WORDS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LN_WORDS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ctl     = '0;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (word_vld) begin
      if (sav_mark) begin
        ctl.restart = 1'b1;
        phase_d     = PH_BODY;
      end else begin
        unique case (phase_q)
          PH_BODY: begin
            ctl.advance = 1'b1;
            if (eav_mark) begin
              phase_d = PH_LNUM;
              cnt_d   = '0;
            end
          end
          PH_LNUM: begin
            ctl.advance = 1'b1;
            if (cnt_q == CNT_LAST) begin
              phase_d = PH_CRLO;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_CRLO: begin
            ctl.cap_lo = 1'b1;
            phase_d    = PH_CRHI;
          end
          PH_CRHI: begin
            ctl.cap_hi = 1'b1;
            phase_d    = PH_IDLE;
          end
          default: begin
            phase_d = PH_IDLE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (word_vld) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3 R4 (input framing assumption)
  marker_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_mark || eav_mark) |-> (word_vld && !(sav_mark && eav_mark)));

  // R5
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.cap_lo |=> (!ctl.advance && !ctl.cap_lo));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> (!ctl.advance && !ctl.cap_lo && !ctl.cap_hi));

endmodule

// File: rtl/hdcrc_chan.sv
module hdcrc_chan #(
  parameter int DATA_W = 10,
  parameter int CRC_W  = 18,
  parameter logic [CRC_W-1:0] POLY = 18'h00031
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hdcrc_pkg::step_t  ctl,
  input  logic [DATA_W-1:0] din,
  input  logic              err_clr,
  output logic              err_pulse,
  output logic              err_sticky
);

  localparam int HALF = CRC_W / 2;

  logic [CRC_W-1:0] crc_q;
  logic [HALF-1:0]  lo_q;
  logic [CRC_W-1:0] rx_crc;
  logic             mism;
  logic             pulse_d, sticky_d;

  hdcrc_lfsr #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctl.restart),
    .advance (ctl.advance),
    .din     (din),
    .crc_q   (crc_q)
  );

  assign rx_crc = {din[HALF-1:0], lo_q};

  always_comb begin
    mism     = ctl.cap_hi && (rx_crc != crc_q);
    pulse_d  = mism;
    sticky_d = mism | (err_sticky & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (ctl.cap_lo) begin
      lo_q <= din[HALF-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_pulse  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      err_pulse  <= pulse_d;
      err_sticky <= sticky_d;
    end
  end

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R7
  pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_sticky);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !err_clr) |=> err_sticky);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !ctl.cap_hi) |=> !err_sticky);

endmodule

// File: rtl/hdcrc_line_checker.sv
module hdcrc_line_checker #(
  parameter int DATA_W   = 10,
  parameter int CRC_W    = 18,
  parameter int LN_WORDS = 2,
  parameter logic [CRC_W-1:0] POLY = 18'h00031
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic              sav_mark,
  input  logic              eav_mark,
  input  logic [DATA_W-1:0] luma_in,
  input  logic [DATA_W-1:0] chroma_in,
  input  logic              err_clr,
  output logic              luma_err_pulse,
  output logic              chroma_err_pulse,
  output logic              luma_err_sticky,
  output logic              chroma_err_sticky
);
  import hdcrc_pkg::*;

  localparam int NCH = 2;

  step_t             ctl;
  logic [DATA_W-1:0] lane [NCH];
  logic [NCH-1:0]    pulse_v;
  logic [NCH-1:0]    sticky_v;

  assign lane[0] = luma_in;
  assign lane[1] = chroma_in;

  hdcrc_seq #(.LN_WORDS(LN_WORDS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .sav_mark (sav_mark),
    .eav_mark (eav_mark),
    .ctl      (ctl)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    hdcrc_chan #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl        (ctl),
      .din        (lane[g]),
      .err_clr    (err_clr),
      .err_pulse  (pulse_v[g]),
      .err_sticky (sticky_v[g])
    );
  end

  assign luma_err_pulse    = pulse_v[0];
  assign chroma_err_pulse  = pulse_v[1];
  assign luma_err_sticky   = sticky_v[0];
  assign chroma_err_sticky = sticky_v[1];

endmodule

// File: tb/sim_hdcrc_line_checker.sv
`timescale 1ns/1ps
module sim_hdcrc_line_checker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       word_vld, sav_mark, eav_mark, err_clr;
  logic [9:0] luma_in, chroma_in;
  logic       luma_err_pulse, chroma_err_pulse, luma_err_sticky, chroma_err_sticky;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  hdcrc_line_checker u0 (
    .clk (clk), .rst_n (rst_n), .word_vld (word_vld),
    .sav_mark (sav_mark), .eav_mark (eav_mark),
    .luma_in (luma_in), .chroma_in (chroma_in), .err_clr (err_clr),
    .luma_err_pulse (luma_err_pulse), .chroma_err_pulse (chroma_err_pulse),
    .luma_err_sticky (luma_err_sticky), .chroma_err_sticky (chroma_err_sticky)
  );

  // R1 arithmetic model
  function automatic logic [17:0] ref_step(input logic [17:0] c, input logic [9:0] w);
    for (int i = 0; i < 10; i++) begin
      logic fb;
      fb = c[0] ^ w[i];
      c  = c >> 1;
      if (fb) c = c ^ 18'h23000;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] l, input logic [9:0] c, input logic v,
                     input logic s, input logic e, input logic clr);
    luma_in = l; chroma_in = c; word_vld = v; sav_mark = s; eav_mark = e; err_clr = clr;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_line(input int n, input int seed, input logic [17:0] lf,
                          input logic [17:0] cf, input bit b9, input bit gaps, input bit clr_hi);
    logic [17:0] lc, cc, lt, ct;
    logic [9:0]  wl, wc;
    logic [9:0]  eav_w [4];
    eav_w[0] = 10'h3FF; eav_w[1] = 10'h000; eav_w[2] = 10'h000; eav_w[3] = 10'h274;
    lc = '0; cc = '0;
    put(10'h3FF, 10'h3FF, 1, 0, 0, 0);
    put(10'h000, 10'h000, 1, 0, 0, 0);
    put(10'h000, 10'h000, 1, 0, 0, 0);
    put(10'h200, 10'h200, 1, 1, 0, 0);
    for (int k = 0; k < n; k++) begin
      wl = 10'((k * 149 + seed * 23 + 3) % 1024);
      wc = 10'((k * 211 + seed * 57 + 700) % 1024);
      lc = ref_step(lc, wl); cc = ref_step(cc, wc);
      put(wl, wc, 1, 0, 0, 0);
      // R8: gap word carries garbage
      if (gaps && (k % 2 == 0)) put(~wl, ~wc, 0, 0, 0, 0);
    end
    for (int k = 0; k < 4; k++) begin
      lc = ref_step(lc, eav_w[k]); cc = ref_step(cc, eav_w[k]);
      put(eav_w[k], eav_w[k], 1, 0, (k == 3), 0);
    end
    // R4: two line-number words
    wl = 10'(seed * 4 + 1); wc = 10'h200 | 10'(seed % 64);
    lc = ref_step(lc, wl); cc = ref_step(cc, wl);
    put(wl, wl, 1, 0, 0, 0);
    lc = ref_step(lc, wc); cc = ref_step(cc, wc);
    put(wc, wc, 1, 0, 0, 0);
    lt = lc ^ lf; ct = cc ^ cf;
    // R5: low half then high half, bit 9 inverse of bit 8 unless b9
    put({~lt[8] ^ b9, lt[8:0]}, {~ct[8] ^ b9, ct[8:0]}, 1, 0, 0, 0);
    put({~lt[17] ^ b9, lt[17:9]}, {~ct[17] ^ b9, ct[17:9]}, 1, 0, 0, clr_hi);
    check("R1 R2 R6 luma pulse", luma_err_pulse, lf != 0);
    check("R1 R2 R6 chroma pulse", chroma_err_pulse, cf != 0);
    put(10'h000, 10'h000, 1, 0, 0, 0);
    check("R6 luma pulse width", luma_err_pulse, 1'b0);
    check("R6 chroma pulse width", chroma_err_pulse, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    luma_in = '0; chroma_in = '0; word_vld = 0; sav_mark = 0; eav_mark = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    check("R3 reset luma pulse", luma_err_pulse, 1'b0);
    check("R3 reset chroma pulse", chroma_err_pulse, 1'b0);
    check("R7 reset luma sticky", luma_err_sticky, 1'b0);
    check("R7 reset chroma sticky", chroma_err_sticky, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: end code, line numbers and check words with no start since reset
    put(10'h3FF, 10'h3FF, 1, 0, 0, 0);
    put(10'h274, 10'h274, 1, 0, 1, 0);
    for (int k = 0; k < 6; k++) begin
      put(10'(k * 97 + 5), 10'(k * 31 + 9), 1, 0, 0, 0);
      check("R9 luma no check", luma_err_pulse, 1'b0);
      check("R9 chroma no check", chroma_err_pulse, 1'b0);
    end

    // Sweep of line length, corruption pattern, bit 9 and gaps
    for (int n = 0; n <= 40; n++) begin
      for (int v = 0; v < 4; v++) begin
        logic [17:0] lf, cf;
        lf = (v & 1) ? (18'h1 << (n % 18)) : 18'h0;
        cf = (v & 2) ? (18'h1 << ((n + 5) % 18)) : 18'h0;
        // R3: valid words before the start code are outside the line
        put(10'(n * 13 + v), 10'(n * 7 + 3 * v), 1, 0, 0, 0);
        run_line(n, n * 4 + v, lf, cf, (v == 0) && (n % 3 == 0), n % 2, 0);
        check("R7 luma sticky set", luma_err_sticky, lf != 0);
        check("R7 chroma sticky set", chroma_err_sticky, cf != 0);
        put(10'h000, 10'h000, 0, 0, 0, 1);
        check("R7 luma sticky cleared", luma_err_sticky, 1'b0);
        check("R7 chroma sticky cleared", chroma_err_sticky, 1'b0);
      end
    end

    // R10: a start code mid-line abandons the partial line
    put(10'h200, 10'h200, 1, 1, 0, 0);
    for (int k = 0; k < 5; k++) put(10'(k * 61 + 2), 10'(k * 17 + 1), 1, 0, 0, 0);
    run_line(7, 99, 18'h0, 18'h0, 0, 0, 0);
    check("R10 luma restart", luma_err_sticky, 1'b0);
    check("R10 chroma restart", chroma_err_sticky, 1'b0);

    // R7: sticky holds across a later good line
    run_line(5, 3, 18'h00100, 18'h0, 0, 0, 0);
    run_line(6, 4, 18'h0, 18'h0, 0, 1, 0);
    check("R7 luma sticky hold", luma_err_sticky, 1'b1);
    check("R7 chroma stays clear", chroma_err_sticky, 1'b0);
    put(10'h000, 10'h000, 0, 0, 0, 1);
    check("R7 luma clear after hold", luma_err_sticky, 1'b0);

    // R7: error and clear on the same edge leaves the bit set
    run_line(4, 8, 18'h0, 18'h20000, 0, 0, 1);
    check("R7 chroma set beats clear", chroma_err_sticky, 1'b1);
    check("R7 luma clear with no error", luma_err_sticky, 1'b0);
    put(10'h000, 10'h000, 0, 0, 0, 1);
    check("R7 chroma cleared", chroma_err_sticky, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule